// File: doc/BRIEF.md
# Halt wake controller

This block is the low-power halt logic beside a small CPU core. When the core asks to halt, the block records the programmed halt depth and the USB suspend flag, then holds the core halted. It watches a set of interrupt request lines. Each line carries a source class, a 3-bit priority level and a per-line enable. The block decides whether a pending request may end the halt in the recorded depth.

When a request may end the halt, the block sends a one-cycle wake pulse. A flag sent with the pulse tells the core what to do next. It either enters interrupt service or carries on with the instruction after the halt. In the deepest mode, a programmable warm-up count has to run out before the pulse is sent, so the clock source has time to settle.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `halted_o`, `wake_o`, `take_int_o` and `warming_o` are 0. Asserting reset while the block is halted clears the halt.
- R2: If `halt_req_i` is high in the running state while no wake pulse is out, `halted_o` goes to 1 at the next clock edge. At that same edge `mode_i` and `usb_suspend_i` are captured. Later changes to either input do not affect the current halt.
- R3: A source is eligible only while its request line is high and its class may wake from the captured mode. The modes are 0 = light idle, 1 = deep idle, 2 = stop and 3 = treated as 0. Class 0 (non-maskable) and class 1 (external, timekeeping or key) may wake from every mode. Class 2 (on-chip peripheral) and class 4 (ordinary USB event) may wake only from mode 0. Class 3 (USB suspend-exit event) may wake from mode 0, and from mode 1 under the condition in R7. Classes 5 to 7 never wake. A high request that is not eligible leaves `halted_o` at 1 and produces no wake pulse.
- R4: If a wake comes from a source with its enable high, `int_enable_i` high and level >= `mask_i`, then `take_int_o` is 1 during the wake pulse.
- R5: If every eligible source has a level below the mask, or has its enable low, or `int_enable_i` is low, the halt still ends. `take_int_o` is then 0 during the pulse, meaning sequential resume. `take_int_o` is never 1 outside a wake pulse.
- R6: A class 0 source counts as level 7. It sets `take_int_o` to 1 whatever the values of its level field, its enable, `int_enable_i` and `mask_i`.
- R7: A class 3 source wakes from mode 1 only if `usb_suspend_i` was high at the edge where the halt was entered.
- R8: In mode 0, 1 or 3, suppose an eligible request is sampled at clock edge k. Then `wake_o` is high in the cycle after edge k. In mode 2, `warming_o` is high from edge k+1 until the wake edge, and `wake_o` is high in the cycle after edge k+1+W, where W is `warmup_i` sampled at edge k.
- R9: `wake_o` is high for exactly one cycle. `halted_o` falls at the same edge where `wake_o` rises.
- R10: A high `halt_req_i` during the wake pulse cycle is ignored, so `halted_o` stays 0. `halt_req_i` is also ignored while the block is halted or warming up.
- R11: Mode 3 behaves exactly like mode 0, including wake timing and class permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Halt depth to use on the next halt request |
| halt_req_i | input | 1 | Halt request from the core |
| usb_suspend_i | input | 1 | USB suspend or clock-stop flag |
| int_enable_i | input | 1 | Global interrupt enable of the core |
| mask_i | input | 3 | Current interrupt mask level |
| irq_i | input | NUM_SRC | Interrupt request lines |
| irq_en_i | input | NUM_SRC | Per-line interrupt enable |
| irq_level_i | input | 3*NUM_SRC | Per-line priority level, line i at bits [3i+2:3i] |
| irq_class_i | input | 3*NUM_SRC | Per-line source class, line i at bits [3i+2:3i] |
| warmup_i | input | CNT_W | Warm-up cycle count for leaving stop mode |
| halted_o | output | 1 | Core is held in halt |
| warming_o | output | 1 | Stop-mode warm-up is counting |
| wake_o | output | 1 | One-cycle wake pulse |
| take_int_o | output | 1 | With wake_o: 1 = enter interrupt service, 0 = resume sequentially |

## Verification
The bench sweeps every halt mode, every suspend value captured at entry, all eight classes and all eight levels. It also covers each combination of the line enable and the global enable. The mask rotates from trial to trial, and the suspend flag is flipped after entry. Permitted and forbidden class/mode pairs are told apart by whether a wake occurs at all. The level, mask and enable combinations are told apart by the take flag. Stop mode is told apart from the idle modes by the counted wake latency, using warm-up values of 0, 1 and 2, and mode 3 is checked against mode 0.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

  localparam int LVL_W = 3;
  localparam int CLS_W = 3;
  localparam logic [LVL_W-1:0] NMI_LEVEL = '1;

  typedef enum logic [1:0] {
    HM_IDLE_LIGHT = 2'd0,
    HM_IDLE_DEEP  = 2'd1,
    HM_STOP       = 2'd2,
    HM_RSVD       = 2'd3
  } halt_mode_e;

  typedef enum logic [CLS_W-1:0] {
    SC_NMI      = 3'd0,
    SC_EXT      = 3'd1,
    SC_PERIPH   = 3'd2,
    SC_USB_WAKE = 3'd3,
    SC_USB_MISC = 3'd4,
    SC_RSVD5    = 3'd5,
    SC_RSVD6    = 3'd6,
    SC_RSVD7    = 3'd7
  } src_class_e;

  typedef enum logic [1:0] {
    FS_RUN  = 2'd0,
    FS_HALT = 2'd1,
    FS_WARM = 2'd2
  } fsm_state_e;

  function automatic halt_mode_e norm_mode(halt_mode_e m);
    return (m == HM_RSVD) ? HM_IDLE_LIGHT : m;
  endfunction

  function automatic logic class_may_wake(src_class_e cls, halt_mode_e mode, logic susp);
    halt_mode_e m;
    logic ok;
    m = norm_mode(mode);
    case (cls)
      SC_NMI, SC_EXT:          ok = 1'b1;
      SC_PERIPH, SC_USB_MISC:  ok = (m == HM_IDLE_LIGHT);
      SC_USB_WAKE:             ok = (m == HM_IDLE_LIGHT) || ((m == HM_IDLE_DEEP) && susp);
      default:                 ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/hw_src_eval.sv
module hw_src_eval
  import halt_wake_pkg::*;
(
  input  logic             req_i,
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [CLS_W-1:0] class_i,
  input  halt_mode_e       mode_i,
  input  logic             susp_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             ie_i,
  output logic             wake_ok_o,
  output logic             service_ok_o
);
  src_class_e       cls;
  logic             is_nmi;
  logic [LVL_W-1:0] eff_level;

  always_comb begin
    cls          = src_class_e'(class_i);
    is_nmi       = (cls == SC_NMI);
    eff_level    = is_nmi ? NMI_LEVEL : level_i;
    wake_ok_o    = req_i && class_may_wake(cls, mode_i, susp_i);
    // non-maskable ignores enables; level 7 always meets the mask
    service_ok_o = wake_ok_o && (is_nmi || (en_i && ie_i && (eff_level >= mask_i)));
  end
endmodule

// File: rtl/hw_warmup_cnt.sv
module hw_warmup_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hw_halt_fsm.sv
module hw_halt_fsm
  import halt_wake_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_req_i,
  input  halt_mode_e mode_i,
  input  logic       susp_i,
  input  logic       any_wake_i,
  input  logic       any_service_i,
  input  logic       cnt_zero_i,
  output halt_mode_e mode_q_o,
  output logic       susp_q_o,
  output logic       cnt_load_o,
  output logic       halted_o,
  output logic       warming_o,
  output logic       wake_o,
  output logic       take_int_o
);
  fsm_state_e state_q;
  halt_mode_e mode_q;
  logic       susp_q, wake_q, take_q, take_pend_q;
  logic       to_stop;

  assign to_stop    = (norm_mode(mode_q) == HM_STOP);
  assign cnt_load_o = (state_q == FS_HALT) && any_wake_i && to_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= FS_RUN;
      mode_q      <= HM_IDLE_LIGHT;
      susp_q      <= 1'b0;
      wake_q      <= 1'b0;
      take_q      <= 1'b0;
      take_pend_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      take_q <= 1'b0;
      case (state_q)
        FS_RUN: begin
          if (halt_req_i && !wake_q) begin
            state_q <= FS_HALT;
            mode_q  <= mode_i;
            susp_q  <= susp_i;
          end
        end
        FS_HALT: begin
          if (any_wake_i) begin
            take_pend_q <= any_service_i;
            if (to_stop) begin
              state_q <= FS_WARM;
            end else begin
              state_q <= FS_RUN;
              wake_q  <= 1'b1;
              take_q  <= any_service_i;
            end
          end
        end
        FS_WARM: begin
          if (cnt_zero_i) begin
            state_q <= FS_RUN;
            wake_q  <= 1'b1;
            take_q  <= take_pend_q;
          end
        end
        default: state_q <= FS_RUN;
      endcase
    end
  end

  assign mode_q_o   = mode_q;
  assign susp_q_o   = susp_q;
  assign halted_o   = (state_q != FS_RUN);
  assign warming_o  = (state_q == FS_WARM);
  assign wake_o     = wake_q;
  assign take_int_o = take_q;
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic                     halt_req_i,
  input  logic                     usb_suspend_i,
  input  logic                     int_enable_i,
  input  logic [LVL_W-1:0]         mask_i,
  input  logic [NUM_SRC-1:0]       irq_i,
  input  logic [NUM_SRC-1:0]       irq_en_i,
  input  logic [NUM_SRC*LVL_W-1:0] irq_level_i,
  input  logic [NUM_SRC*CLS_W-1:0] irq_class_i,
  input  logic [CNT_W-1:0]         warmup_i,
  output logic                     halted_o,
  output logic                     warming_o,
  output logic                     wake_o,
  output logic                     take_int_o
);
  halt_mode_e         mode_q;
  logic               susp_q;
  logic [NUM_SRC-1:0] wake_ok, service_ok;
  logic               cnt_load, cnt_zero;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    hw_src_eval u_eval (
      .req_i        (irq_i[i]),
      .en_i         (irq_en_i[i]),
      .level_i      (irq_level_i[i*LVL_W +: LVL_W]),
      .class_i      (irq_class_i[i*CLS_W +: CLS_W]),
      .mode_i       (mode_q),
      .susp_i       (susp_q),
      .mask_i       (mask_i),
      .ie_i         (int_enable_i),
      .wake_ok_o    (wake_ok[i]),
      .service_ok_o (service_ok[i])
    );
  end

  hw_halt_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .halt_req_i    (halt_req_i),
    .mode_i        (halt_mode_e'(mode_i)),
    .susp_i        (usb_suspend_i),
    .any_wake_i    (|wake_ok),
    .any_service_i (|service_ok),
    .cnt_zero_i    (cnt_zero),
    .mode_q_o      (mode_q),
    .susp_q_o      (susp_q),
    .cnt_load_o    (cnt_load),
    .halted_o      (halted_o),
    .warming_o     (warming_o),
    .wake_o        (wake_o),
    .take_int_o    (take_int_o)
  );

  hw_warmup_cnt #(.CNT_W(CNT_W)) u_warm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (warmup_i),
    .run_i      (warming_o),
    .zero_o     (cnt_zero)
  );
endmodule

// File: rtl/halt_wake_ctrl_chk.sv
module halt_wake_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic halt_req_i,
  input logic halted_o,
  input logic warming_o,
  input logic wake_o,
  input logic take_int_o
);
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R9
  AST_WAKE_LEAVES_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> (!halted_o && $past(halted_o))); // R9
  AST_TAKE_WITH_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_int_o |-> wake_o); // R5
  AST_NO_REHALT_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !halted_o); // R10
  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !wake_o && halt_req_i) |=> halted_o); // R2
  AST_WARM_IN_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warming_o |-> (halted_o && !wake_o)); // R8
endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_req_i (halt_req_i),
  .halted_o   (halted_o),
  .warming_o  (warming_o),
  .wake_o     (wake_o),
  .take_int_o (take_int_o)
);

// File: tb/sim_halt_wake_ctrl.sv
module sim_halt_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode = '0;
  logic          halt_req = 1'b0, susp = 1'b0, ie = 1'b0;
  logic [2:0]    mask = '0;
  logic [NS-1:0] irq = '0, irq_en = '0;
  logic [NS*3-1:0] lvl = '0, cls = '0;
  logic [CW-1:0] warm = '0;
  logic          halted, warming, wake, take;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_wake_ctrl #(.NUM_SRC(NS), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .halt_req_i(halt_req),
    .usb_suspend_i(susp), .int_enable_i(ie), .mask_i(mask), .irq_i(irq),
    .irq_en_i(irq_en), .irq_level_i(lvl), .irq_class_i(cls), .warmup_i(warm),
    .halted_o(halted), .warming_o(warming), .wake_o(wake), .take_int_o(take)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_allow(int m, int c, logic s);
    int mn = (m == 3) ? 0 : m;
    if (c == 0 || c == 1) return 1'b1;
    if (c == 2 || c == 4) return mn == 0;
    if (c == 3) return (mn == 0) || (mn == 1 && s);
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 200000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // wait for wake pulse; returns negedges counted, 0 if none in limit
  task automatic wait_wake(input int lim, output int cnt, output logic w1, output logic tk);
    cnt = 0; w1 = 1'b0; tk = 1'b0;
    for (int n = 1; n <= lim; n++) begin
      @(negedge clk);
      if (n == 1) w1 = warming;
      if (wake) begin cnt = n; tk = take; break; end
    end
  endtask

  task automatic finish_pulse();
    chk(halted == 1'b0, "R9", halted, 0);
    halt_req = 1'b1;
    irq = '0;
    @(negedge clk);
    chk(wake == 1'b0, "R9", wake, 0);
    chk(halted == 1'b0, "R10", halted, 0);
    halt_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic trial(input int m, input logic s, input int c, input int l,
                       input logic e, input logic g, input int mk, input int w);
    logic al, tk_exp, w1, tk;
    int mn, cnt, exp_cnt;
    string tg;
    mn = (m == 3) ? 0 : m;
    al = exp_allow(m, c, s);
    tk_exp = (c == 0) || (e && g && (l >= mk));
    exp_cnt = (mn == 2) ? w + 2 : 1;
    mode = m[1:0]; susp = s; halt_req = 1'b1;
    mask = mk[2:0]; ie = g; warm = w[CW-1:0];
    irq_en = {1'b0, e}; lvl = {3'd7, l[2:0]}; cls = {3'd0, c[2:0]};
    @(negedge clk);
    chk(halted == 1'b1, "R2", halted, 1);
    halt_req = 1'b0;
    mode = ~m[1:0]; susp = ~s;  // captured values must hold
    irq[0] = 1'b1;
    if (al) begin
      wait_wake(w + 8, cnt, w1, tk);
      tg = (m == 3) ? "R11" : (mn == 2) ? "R8" : (c == 3) ? "R7" : "R3";
      chk(cnt == exp_cnt, tg, cnt, exp_cnt);
      if (mn == 2) chk(w1 == 1'b1, "R8", w1, 1);
      tg = (c == 0) ? "R6" : tk_exp ? "R4" : "R5";
      chk(tk == tk_exp, tg, tk, tk_exp);
      if (cnt != 0) finish_pulse();
    end else begin
      wait_wake(w + 6, cnt, w1, tk);
      tg = (c == 3) ? "R7" : "R3";
      chk(cnt == 0 && halted == 1'b1 && warming == 1'b0, tg, cnt, 0);
      irq[1] = 1'b1;  // non-maskable release
      wait_wake(w + 8, cnt, w1, tk);
      chk(cnt != 0 && tk == 1'b1, "R6", tk, 1);
      if (cnt != 0) finish_pulse();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(halted == 0 && wake == 0 && take == 0 && warming == 0, "R1", halted, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(halted == 0 && wake == 0 && take == 0 && warming == 0, "R1", wake, 0);
    begin
      int idx = 0;
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 8; c++)
            for (int l = 0; l < 8; l++)
              for (int e = 0; e < 2; e++)
                for (int g = 0; g < 2; g++) begin
                  trial(m, s[0], c, l, e[0], g[0], (idx * 3 + c) % 8, idx % 3);
                  idx++;
                end
    end
    // halt request while warming is ignored, reset clears halt
    mode = 2'd2; warm = 16'd5; halt_req = 1'b1; cls = '0; irq_en = '0;
    @(negedge clk);
    halt_req = 1'b0; irq[1] = 1'b1;
    @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    chk(warming == 1'b1 && halted == 1'b1, "R10", warming, 1);
    halt_req = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(halted == 1'b0 && warming == 1'b0, "R1", halted, 0);
    irq = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(halted == 1'b0 && wake == 1'b0, "R1", halted, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule